// File: doc/BRIEF.md
# Receive Synchronisation-Request Controller

This block decides when a multi-gigabit converter-link receiver withdraws its synchronisation request. It drives the active-low `sync_n` line back to the transmitter. It does this by watching a decoded character stream for an unbroken run of comma control characters. For deterministic-latency subclasses, it also holds the release until a SYSREF rising edge has been sampled since link reset. The release then waits for the next wrap of the local multiframe counter, so that it follows the realigned frame timing and not a free-running one.

Characters arrive on a valid/ready interface. The block never applies back-pressure out of reset: `chr_ready` equals `link_rst_n`, so characters offered during link reset are dropped and every character offered afterwards is accepted on the edge where `chr_valid` is high. A cycle with `chr_valid` low carries no character.

The `cgs_done` status flag reports that code-group sync has been reached. The flag can be high while `sync_n` is still held low, waiting for SYSREF or for a multiframe boundary.

Top module: `sync_req_ctrl`

## Requirements
- R1: While `link_rst_n` is low, `sync_n`, `cgs_done` and `chr_ready` are all low. Out of reset, `chr_ready` is high.
- R2: A comma is an accepted character with `chr_data` equal to 8'hBC and `chr_is_ctl` equal to 1. After the edge that accepts the fourth consecutive comma, `cgs_done` goes high one clock edge later.
- R3: Before code-group sync, any accepted non-comma restarts the comma run. This includes 8'hBC with `chr_is_ctl` 0, and any other control character, including long runs of such control characters.
- R4: A cycle with `chr_valid` low neither advances nor breaks the comma run.
- R5: With `subclass` equal to 0, `sync_n` rises on the same edge as `cgs_done`.
- R6: With `subclass` nonzero (1, 2 or 3), `sync_n` stays low until a SYSREF rising edge has been seen since link reset. SYSREF passes through a two-flop synchroniser, and the seen flag is sticky.
- R7: With `subclass` nonzero, once `cgs_done` is high and SYSREF has been seen, `sync_n` rises on the first clock edge at which `lmfc_cnt` equals 0.
- R8: Subclass 2 behaves exactly like subclass 1. A SYSREF edge seen before code-group sync still counts.
- R9: Once high, `sync_n` and `cgs_done` stay high until link reset. Link reset also clears the SYSREF-seen flag.
- R10: `sync_n` is never high while `cgs_done` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Link clock |
| link_rst_n | input | 1 | Link reset, active low, asynchronous assert |
| subclass | input | 2 | Deterministic-latency mode: 0, 1, 2 (3 treated as 1) |
| chr_valid | input | 1 | Character present this cycle |
| chr_ready | output | 1 | Character accepted (high out of reset) |
| chr_data | input | 8 | Decoded character value |
| chr_is_ctl | input | 1 | Character is a control symbol |
| sysref | input | 1 | Asynchronous SYSREF reference |
| lmfc_cnt | input | 5 | Local multiframe counter, 0 marks a boundary |
| sync_n | output | 1 | Synchronisation request, low = requesting |
| cgs_done | output | 1 | Code-group sync achieved |

## Verification
The assertions take for granted that `subclass` only changes while link reset is asserted. They also assume that `lmfc_cnt` visits 0 periodically, and that a SYSREF pulse is at least one clock wide so the synchroniser can catch it. The stimulus therefore sets the subclass only during reset cycles, drives the multiframe counter as a modulo-8 count, and holds SYSREF high for two cycles. SYSREF is never left high across a reset release, which would make it ambiguous whether a rising edge occurred after reset.

// File: rtl/sreq_pkg.sv
package sreq_pkg;
  typedef enum logic [1:0] {
    ST_REQ   = 2'd0,
    ST_ALIGN = 2'd1,
    ST_DONE  = 2'd2
  } sreq_state_e;

  localparam logic [1:0] SUBCLASS_FREE = 2'd0;
endpackage

// File: rtl/sreq_sysref_catch.sv
module sreq_sysref_catch #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sysref_i,
  output logic seen_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;
  logic              seen_q;

  for (genvar g = 0; g < STAGES; g++) begin : g_sync
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_q[g] <= 1'b0;
      else if (g == 0) sync_q[g] <= sysref_i;
      else sync_q[g] <= sync_q[(g == 0) ? 0 : g-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      seen_q <= 1'b0;
    end else begin
      prev_q <= sync_q[STAGES-1];
      if (sync_q[STAGES-1] && !prev_q) seen_q <= 1'b1;
    end
  end

  assign seen_o = seen_q;
endmodule

// File: rtl/sreq_comma_run.sv
module sreq_comma_run #(
  parameter int          DATA_W = 8,
  parameter logic [7:0]  COMMA  = 8'hBC,
  parameter int          RUN    = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              valid_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              is_ctl_i,
  output logic              run_met_o
);
  localparam int CNT_W = $clog2(RUN + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(RUN);

  logic [CNT_W-1:0] cnt_q;
  logic             is_comma;

  assign is_comma = is_ctl_i && (data_i == DATA_W'(COMMA));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else if (valid_i) begin
      if (!is_comma) cnt_q <= '0;
      else if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign run_met_o = (cnt_q == CNT_MAX);
endmodule

// File: rtl/sreq_release_fsm.sv
module sreq_release_fsm
  import sreq_pkg::*;
#(
  parameter int LMFC_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_met_i,
  input  logic              gate_i,
  input  logic              seen_i,
  input  logic [LMFC_W-1:0] lmfc_i,
  output logic              sync_n_o,
  output logic              cgs_o
);
  sreq_state_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_REQ:   if (run_met_i) st_d = gate_i ? ST_ALIGN : ST_DONE;
      ST_ALIGN: if (seen_i && (lmfc_i == '0)) st_d = ST_DONE;
      ST_DONE:  st_d = ST_DONE;
      default:  st_d = ST_REQ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_REQ;
    else st_q <= st_d;
  end

  assign sync_n_o = (st_q == ST_DONE);
  assign cgs_o    = (st_q != ST_REQ);
endmodule

// File: rtl/sync_req_ctrl.sv
module sync_req_ctrl
  import sreq_pkg::*;
#(
  parameter int         DATA_W        = 8,
  parameter logic [7:0] COMMA         = 8'hBC,
  parameter int         COMMA_RUN     = 4,
  parameter int         LMFC_W        = 5,
  parameter int         SYSREF_STAGES = 2
) (
  input  logic              clk,
  input  logic              link_rst_n,
  input  logic [1:0]        subclass,
  input  logic              chr_valid,
  output logic              chr_ready,
  input  logic [DATA_W-1:0] chr_data,
  input  logic              chr_is_ctl,
  input  logic              sysref,
  input  logic [LMFC_W-1:0] lmfc_cnt,
  output logic              sync_n,
  output logic              cgs_done
);
  logic run_met;
  logic sysref_seen;
  logic gate_sysref;
  logic accept;

  assign chr_ready   = link_rst_n;
  assign accept      = chr_valid && chr_ready;
  assign gate_sysref = (subclass != SUBCLASS_FREE);

  sreq_comma_run #(
    .DATA_W (DATA_W),
    .COMMA  (COMMA),
    .RUN    (COMMA_RUN)
  ) u_run (
    .clk       (clk),
    .rst_n     (link_rst_n),
    .valid_i   (accept),
    .data_i    (chr_data),
    .is_ctl_i  (chr_is_ctl),
    .run_met_o (run_met)
  );

  sreq_sysref_catch #(
    .STAGES (SYSREF_STAGES)
  ) u_sysref (
    .clk      (clk),
    .rst_n    (link_rst_n),
    .sysref_i (sysref),
    .seen_o   (sysref_seen)
  );

  sreq_release_fsm #(
    .LMFC_W (LMFC_W)
  ) u_fsm (
    .clk       (clk),
    .rst_n     (link_rst_n),
    .run_met_i (run_met),
    .gate_i    (gate_sysref),
    .seen_i    (sysref_seen),
    .lmfc_i    (lmfc_cnt),
    .sync_n_o  (sync_n),
    .cgs_o     (cgs_done)
  );
endmodule

// File: rtl/sync_req_ctrl_chk.sv
module sync_req_ctrl_chk #(
  parameter int LMFC_W = 5
) (
  input logic              clk,
  input logic              link_rst_n,
  input logic [1:0]        subclass,
  input logic [LMFC_W-1:0] lmfc_cnt,
  input logic              sync_n,
  input logic              cgs_done,
  input logic              run_met,
  input logic              sysref_seen
);
  AST_RST_HOLDS_LOW: assert property (@(posedge clk)
    !link_rst_n |-> (!sync_n && !cgs_done)); // R1

  AST_CGS_AFTER_RUN: assert property (@(posedge clk) disable iff (!link_rst_n)
    $rose(cgs_done) |-> $past(run_met)); // R2

  AST_FREE_RELEASE_WITH_CGS: assert property (@(posedge clk) disable iff (!link_rst_n)
    ($rose(cgs_done) && subclass == 2'd0) |-> sync_n); // R5

  AST_GATED_NEEDS_SYSREF: assert property (@(posedge clk) disable iff (!link_rst_n)
    ($rose(sync_n) && subclass != 2'd0) |-> $past(sysref_seen)); // R6

  AST_GATED_ON_BOUNDARY: assert property (@(posedge clk) disable iff (!link_rst_n)
    ($rose(sync_n) && subclass != 2'd0) |-> ($past(lmfc_cnt) == '0)); // R7

  AST_SYNC_STICKY: assert property (@(posedge clk) disable iff (!link_rst_n)
    sync_n |=> sync_n); // R9

  AST_CGS_STICKY: assert property (@(posedge clk) disable iff (!link_rst_n)
    cgs_done |=> cgs_done); // R9

  AST_SYNC_IMPLIES_CGS: assert property (@(posedge clk) disable iff (!link_rst_n)
    sync_n |-> cgs_done); // R10
endmodule

bind sync_req_ctrl sync_req_ctrl_chk #(.LMFC_W(LMFC_W)) u_chk (
  .clk         (clk),
  .link_rst_n  (link_rst_n),
  .subclass    (subclass),
  .lmfc_cnt    (lmfc_cnt),
  .sync_n      (sync_n),
  .cgs_done    (cgs_done),
  .run_met     (run_met),
  .sysref_seen (sysref_seen)
);

// File: tb/test_sync_req_ctrl.sv
module test_sync_req_ctrl;
  logic       clk = 1'b0;
  logic       link_rst_n = 1'b1;
  logic [1:0] subclass = 2'd0;
  logic       chr_valid = 1'b0;
  logic       chr_ready;
  logic [7:0] chr_data = 8'h00;
  logic       chr_is_ctl = 1'b0;
  logic       sysref = 1'b0;
  logic [4:0] lmfc_cnt = 5'd1;
  logic       sync_n;
  logic       cgs_done;

  typedef struct {
    bit    sync;
    bit    cgs;
    bit    rdy;
    string req;
  } exp_t;

  exp_t q[$];
  int   checks = 0;
  int   errors = 0;
  bit   finished = 1'b0;

  always #2 clk = ~clk;

  sync_req_ctrl i_sync_req_ctrl (
    .clk        (clk),
    .link_rst_n (link_rst_n),
    .subclass   (subclass),
    .chr_valid  (chr_valid),
    .chr_ready  (chr_ready),
    .chr_data   (chr_data),
    .chr_is_ctl (chr_is_ctl),
    .sysref     (sysref),
    .lmfc_cnt   (lmfc_cnt),
    .sync_n     (sync_n),
    .cgs_done   (cgs_done)
  );

  // Driver: one character slot per cycle; the expectation is for the outputs after the next edge.
  task automatic step(bit rst, bit v, logic [7:0] d, bit c, bit sr, int lm,
                      bit es, bit ec, string req);
    exp_t e;
    @(negedge clk);
    link_rst_n = rst;
    chr_valid  = v;
    chr_data   = d;
    chr_is_ctl = c;
    sysref     = sr;
    lmfc_cnt   = 5'(lm);
    e.sync = es; e.cgs = ec; e.rdy = rst; e.req = req;
    q.push_back(e);
  endtask

  task automatic kc(int lm, bit sr, bit es, bit ec, string req);
    step(1'b1, 1'b1, 8'hBC, 1'b1, sr, lm, es, ec, req);
  endtask

  task automatic idle(int lm, bit sr, bit es, bit ec, string req);
    step(1'b1, 1'b0, 8'h00, 1'b0, sr, lm, es, ec, req);
  endtask

  task automatic hold_reset(bit [1:0] sc, int n);
    subclass = sc;
    for (int i = 0; i < n; i++)
      step(1'b0, 1'b1, 8'hBC, 1'b1, 1'b0, 0, 1'b0, 1'b0, "R1");
  endtask

  // Monitor: pops one expectation per cycle, sampling after the edge has settled.
  always @(posedge clk) begin
    #1;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (sync_n !== e.sync || cgs_done !== e.cgs || chr_ready !== e.rdy) begin
        errors++;
        $display("FAIL %s: sync_n=%b cgs_done=%b chr_ready=%b expected %b %b %b",
                 e.req, sync_n, cgs_done, chr_ready, e.sync, e.cgs, e.rdy);
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #1 link_rst_n = 1'b0;
    // R1: commas offered during reset are dropped, outputs stay low
    hold_reset(2'd0, 6);

    // Subclass 0, R3: broken runs restart
    kc(1, 0, 0, 0, "R2"); kc(2, 0, 0, 0, "R2"); kc(3, 0, 0, 0, "R2");
    step(1, 1, 8'hBC, 0, 0, 4, 0, 0, "R3");              // comma value without control flag
    kc(5, 0, 0, 0, "R3"); kc(6, 0, 0, 0, "R3"); kc(7, 0, 0, 0, "R3");
    step(1, 1, 8'h7C, 1, 0, 0, 0, 0, "R3");              // other control character
    kc(1, 0, 0, 0, "R3"); kc(2, 0, 0, 0, "R3"); kc(3, 0, 0, 0, "R3");
    step(1, 1, 8'h7C, 1, 0, 4, 0, 0, "R3");              // four control-error characters
    step(1, 1, 8'h1C, 1, 0, 5, 0, 0, "R3");
    step(1, 1, 8'hFC, 1, 0, 6, 0, 0, "R3");
    step(1, 1, 8'h3C, 1, 0, 7, 0, 0, "R3");
    kc(0, 0, 0, 0, "R3"); kc(1, 0, 0, 0, "R3"); kc(2, 0, 0, 0, "R3");
    step(1, 0, 8'h00, 0, 0, 3, 0, 0, "R4");              // bubble keeps run of three
    kc(4, 0, 0, 0, "R4");                                // fourth comma accepted
    idle(5, 0, 1, 1, "R5");                              // sync and cgs rise together
    step(1, 1, 8'h55, 0, 0, 6, 1, 1, "R9");              // data after release keeps it
    idle(7, 0, 1, 1, "R9");

    // Subclass 1: no SYSREF, boundary passes without release
    hold_reset(2'd1, 2);
    kc(1, 0, 0, 0, "R2"); kc(2, 0, 0, 0, "R2"); kc(3, 0, 0, 0, "R2"); kc(4, 0, 0, 0, "R2");
    idle(5, 0, 0, 1, "R2");
    idle(6, 0, 0, 1, "R6"); idle(7, 0, 0, 1, "R6");
    idle(0, 0, 0, 1, "R6"); idle(1, 0, 0, 1, "R6");
    idle(2, 1, 0, 1, "R6"); idle(3, 1, 0, 1, "R6");      // SYSREF pulse, two cycles
    idle(4, 0, 0, 1, "R7"); idle(5, 0, 0, 1, "R7");
    idle(6, 0, 0, 1, "R7"); idle(7, 0, 0, 1, "R7");
    idle(0, 0, 1, 1, "R7");                              // released on the boundary
    idle(1, 0, 1, 1, "R9");

    // Subclass 2: SYSREF before code-group sync
    hold_reset(2'd2, 2);
    kc(1, 1, 0, 0, "R8"); kc(2, 1, 0, 0, "R8"); kc(3, 0, 0, 0, "R8"); kc(4, 0, 0, 0, "R8");
    idle(5, 0, 0, 1, "R8");
    idle(6, 0, 0, 1, "R8"); idle(7, 0, 0, 1, "R8");
    idle(0, 0, 1, 1, "R8");
    idle(1, 0, 1, 1, "R9");

    // Reset clears the seen flag: no release without a new SYSREF
    step(0, 0, 8'h00, 0, 0, 2, 0, 0, "R1");
    step(0, 0, 8'h00, 0, 0, 3, 0, 0, "R1");
    kc(4, 0, 0, 0, "R9"); kc(5, 0, 0, 0, "R9"); kc(6, 0, 0, 0, "R9"); kc(7, 0, 0, 0, "R9");
    idle(0, 0, 0, 1, "R9");
    idle(1, 0, 0, 1, "R9"); idle(0, 0, 0, 1, "R9"); idle(1, 0, 0, 1, "R9");
    idle(0, 0, 0, 1, "R9");

    @(negedge clk);
    while (q.size() > 0) @(negedge clk);
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule